// File: doc/BRIEF.md
# GPIO Interrupt Port

This block is one eight-line general-purpose I/O port with interrupt generation on every line. A byte-wide register bus (address, write enable, write data, registered read data) reaches an output data register and a direction register that drive the pad outputs and their output enables. The pad inputs pass through a two-flop synchronizer. Each line may optionally pass through a debounce filter before interrupt detection.

Each line is configured by two mode bits. One selects level or edge sensitivity, and the other selects the active polarity. Edge events are held in a per-line latch until software clears them with a write-one-to-clear acknowledge register. Level conditions follow the input directly and are never held. An enable mask gates every line. The port reports a masked status byte, one registered interrupt output per line and a combined interrupt output. Software can emulate both-edge triggering by inverting a line's polarity bit at each acknowledge. The detector compares the current sample with the previous one, so the inversion alone never produces an event.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register is zero: all lines are inputs (pad_oe = 0x00), pad_out = 0x00, interrupts are disabled, nothing is pending, irq_line = 0x00 and irq_any = 0.
- R2: A write to address 0x10 sets the direction mask, where 1 means output, and drives pad_oe. A write to 0x00 sets the output data and drives pad_out. A read of 0x00 returns the data bit for output lines and the synchronized pad bit for input lines.
- R3: Mode bits: in the mode register at 0x90 a bit of 0 selects level and 1 selects edge. In the polarity register at 0x94 a bit of 0 selects low or falling and 1 selects high or rising. A level line is pending exactly while its input equals its polarity bit, and writes to the acknowledge register do not affect it.
- R4: An edge line latches an event on a transition of the selected direction. Writing to 0x98 clears the latch of each line written with 1 and leaves lines written with 0 untouched. If a new event arrives in the same cycle as the clear, the event wins.
- R5: The enable register at 0x9C gates every line. A disabled line never becomes pending, latches no edge, and loses any latch it held.
- R6: Changing a line's polarity bit while its input is steady produces no event. The next transition in the new direction is latched.
- R7: The status byte, read at 0xA0, equals (latch OR level match) AND enable. irq_line is that byte registered one cycle later, and irq_any is the OR of irq_line.
- R8: When a line's bit is set in the debounce register at 0xA8, the filtered value changes only after the synchronized input has differed from it on 4 consecutive sample ticks. A sample tick occurs once every DB_DIV clock cycles.
- R9: Without debounce, a level condition reaches irq_line at the third rising edge after the pad changes. An edge event reaches irq_line at the fourth rising edge.
- R10: Reads of the acknowledge register and of any unmapped address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data, valid one cycle after the address |
| pad_in | input | NLINES | Asynchronous pad inputs |
| pad_out | output | NLINES | Output data to the pads |
| pad_oe | output | NLINES | Per-line output enable |
| irq_line | output | NLINES | Registered per-line interrupt |
| irq_any | output | 1 | Registered combined interrupt |

## Verification
Register writes take effect at the rising edge that captures them. Read data appears one edge after the address is presented. Without debounce, a level condition reaches irq_line three edges after a pad change and an edge event reaches it four edges after. The bench drives every input just after a falling edge. The latency checks sample exactly one rising edge before and one rising edge at the edge where each result is due. All other checks, including the random operations checked against a bench model, first wait six cycles so that every pipeline stage has settled. Debounced checks wait a fixed number of cycles chosen to fall clearly below or above the four-tick acceptance window.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_DATA  = 'h00;
  localparam int ADDR_DIR   = 'h10;
  localparam int ADDR_MODE  = 'h90;
  localparam int ADDR_POL   = 'h94;
  localparam int ADDR_ACK   = 'h98;
  localparam int ADDR_EN    = 'h9C;
  localparam int ADDR_STAT  = 'hA0;
  localparam int ADDR_DBEN  = 'hA8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/gpio_tick.sv
module gpio_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en,
  input  logic din,
  output logic dout
);
  localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
      cnt  <= '0;
    end else if (!en) begin
      dout <= din;
      cnt  <= '0;
    end else if (din == dout) begin
      cnt  <= '0;
    end else if (tick) begin
      if (cnt == CW'(STABLE - 1)) begin
        dout <= din;
        cnt  <= '0;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line (
  input  logic clk,
  input  logic rst,
  input  logic det,
  input  logic edge_mode,
  input  logic pol,
  input  logic en,
  input  logic ack,
  output logic pend,
  output logic held
);
  logic prev;
  logic event_hit;
  logic lvl_hit;

  assign event_hit = edge_mode & en & (pol ? (det & ~prev) : (~det & prev));
  assign lvl_hit   = ~edge_mode & (det == pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      held <= 1'b0;
    end else begin
      prev <= det;
      if (!en || !edge_mode) held <= 1'b0;
      else if (event_hit)    held <= 1'b1;
      else if (ack)          held <= 1'b0;
    end
  end

  assign pend = (held | lvl_hit) & en;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int NLINES      = 8,
  parameter int AW          = 8,
  parameter int DB_DIV      = 4,
  parameter int DB_STABLE   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic [NLINES-1:0] irq_line,
  output logic              irq_any
);
  logic [NLINES-1:0] data_q, dir_q, mode_q, pol_q, en_q, dben_q;
  logic [NLINES-1:0] sync_v, filt_v, det_v, status_v, held_v, ack_v;
  logic              tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      dben_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(ADDR_DATA)) data_q <= bus_wdata;
      if (bus_addr == AW'(ADDR_DIR))  dir_q  <= bus_wdata;
      if (bus_addr == AW'(ADDR_MODE)) mode_q <= bus_wdata;
      if (bus_addr == AW'(ADDR_POL))  pol_q  <= bus_wdata;
      if (bus_addr == AW'(ADDR_EN))   en_q   <= bus_wdata;
      if (bus_addr == AW'(ADDR_DBEN)) dben_q <= bus_wdata;
    end
  end

  assign ack_v = (bus_we && bus_addr == AW'(ADDR_ACK)) ? bus_wdata : '0;

  gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(sync_v)
  );

  gpio_tick #(.DIV(DB_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    gpio_debounce #(.STABLE(DB_STABLE)) u_db (
      .clk(clk), .rst(rst), .tick(tick), .en(dben_q[i]),
      .din(sync_v[i]), .dout(filt_v[i])
    );
    assign det_v[i] = dben_q[i] ? filt_v[i] : sync_v[i];
    gpio_irq_line u_irq (
      .clk(clk), .rst(rst), .det(det_v[i]), .edge_mode(mode_q[i]),
      .pol(pol_q[i]), .en(en_q[i]), .ack(ack_v[i]),
      .pend(status_v[i]), .held(held_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_line  <= '0;
      irq_any   <= 1'b0;
    end else begin
      irq_line <= status_v;
      irq_any  <= |status_v;
      case (bus_addr)
        AW'(ADDR_DATA): bus_rdata <= (dir_q & data_q) | (~dir_q & sync_v);
        AW'(ADDR_DIR):  bus_rdata <= dir_q;
        AW'(ADDR_MODE): bus_rdata <= mode_q;
        AW'(ADDR_POL):  bus_rdata <= pol_q;
        AW'(ADDR_EN):   bus_rdata <= en_q;
        AW'(ADDR_STAT): bus_rdata <= status_v;
        AW'(ADDR_DBEN): bus_rdata <= dben_q;
        default:        bus_rdata <= '0;
      endcase
    end
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [NLINES-1:0] pad_oe,
  input logic [NLINES-1:0] irq_line,
  input logic              irq_any,
  input logic [NLINES-1:0] en_q,
  input logic [NLINES-1:0] mode_q,
  input logic [NLINES-1:0] held_v
);
  assert_any_matches_lines_R7: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_line != '0));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_line & ~$past(en_q)) == '0);

  assert_latch_needs_edge_mode_R4: assert property (@(posedge clk) disable iff (rst)
    ((held_v & ~$past(held_v)) & ~($past(mode_q) & $past(en_q))) == '0);

  assert_dir_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == AW'(ADDR_DIR)) |=> $stable(pad_oe));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NLINES(NLINES), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .pad_oe(pad_oe), .irq_line(irq_line), .irq_any(irq_any),
  .en_q(en_q), .mode_q(mode_q), .held_v(held_v)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, irq_line;
  logic       irq_any;

  int n_cmp = 0;
  int n_mis = 0;

  logic [7:0] m_mode, m_pol, m_en, m_lat, m_pad;

  always #5 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_line(irq_line), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_status();
    return (m_lat | (~m_mode & ~(m_pad ^ m_pol))) & m_en;
  endfunction

  task automatic check_status(input string req);
    logic [7:0] r;
    rd(8'hA0, r);
    chk({req, " status"}, r, exp_status());
    chk({req, " irq_line"}, irq_line, exp_status());
    chk({req, " irq_any"}, {7'd0, irq_any}, {7'd0, |exp_status()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_mis++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 irq_line", irq_line, 8'h00);
    chk("R1 irq_any", {7'd0, irq_any}, 8'h00);
    rd(8'hA0, r); chk("R1 status", r, 8'h00);
    rd(8'h9C, r); chk("R1 enable", r, 8'h00);

    // R2 data and direction
    wr(8'h10, 8'hF0);
    wr(8'h00, 8'hA5);
    drive(8'h3C);
    settle(4);
    chk("R2 pad_oe", pad_oe, 8'hF0);
    chk("R2 pad_out", pad_out, 8'hA5);
    rd(8'h00, r); chk("R2 data readback", r, 8'hAC);
    wr(8'h10, 8'h00);
    drive(8'h00);

    // R10 unmapped and acknowledge reads
    rd(8'h04, r); chk("R10 unmapped", r, 8'h00);
    rd(8'h98, r); chk("R10 ack read", r, 8'h00);

    // R9 level latency: high level on line 0
    wr(8'h90, 8'h00); wr(8'h94, 8'h01); wr(8'h9C, 8'h01);
    settle(4);
    @(negedge clk); pad_in = 8'h01;
    repeat (2) @(posedge clk); #1;
    chk("R9 level not before edge 3", irq_line, 8'h00);
    @(posedge clk); #1;
    chk("R9 level at edge 3", irq_line, 8'h01);
    drive(8'h00); settle(6);

    // R9 edge latency: rising edge on line 0
    wr(8'h90, 8'h01);
    settle(4);
    @(negedge clk); pad_in = 8'h01;
    repeat (3) @(posedge clk); #1;
    chk("R9 edge not before edge 4", irq_line, 8'h00);
    @(posedge clk); #1;
    chk("R9 edge at edge 4", irq_line, 8'h01);

    // R4 latch holds after input falls, write-one-to-clear
    drive(8'h00); settle(6);
    rd(8'hA0, r); chk("R4 latch held", r, 8'h01);
    wr(8'h98, 8'hFE); settle(3);
    rd(8'hA0, r); chk("R4 zero bits unaffected", r, 8'h01);
    wr(8'h98, 8'h01); settle(3);
    rd(8'hA0, r); chk("R4 cleared", r, 8'h00);

    // R3 level low mode, ack has no effect
    wr(8'h90, 8'h00); wr(8'h94, 8'h00); wr(8'h9C, 8'hFF);
    drive(8'h0F); settle(6);
    rd(8'hA0, r); chk("R3 level low match", r, 8'hF0);
    wr(8'h98, 8'hFF); settle(3);
    rd(8'hA0, r); chk("R3 ack ignored", r, 8'hF0);
    chk("R3 irq_line", irq_line, 8'hF0);

    // R6 polarity flip without false event
    wr(8'h9C, 8'h00); drive(8'h00);
    wr(8'h90, 8'h02); wr(8'h94, 8'h02); wr(8'h9C, 8'h02);
    settle(4);
    drive(8'h02); settle(6);
    rd(8'hA0, r); chk("R6 rising latched", r, 8'h02);
    wr(8'h98, 8'h02); wr(8'h94, 8'h00); settle(6);
    rd(8'hA0, r); chk("R6 no false event on flip", r, 8'h00);
    drive(8'h00); settle(6);
    rd(8'hA0, r); chk("R6 falling latched", r, 8'h02);

    // R5 disable discards latch and blocks new latching
    wr(8'h9C, 8'h00); settle(2);
    wr(8'h9C, 8'h02); settle(3);
    rd(8'hA0, r); chk("R5 latch discarded", r, 8'h00);
    wr(8'h94, 8'h02); wr(8'h9C, 8'h00);
    drive(8'h02); settle(6);
    chk("R5 disabled irq_line", irq_line, 8'h00);
    wr(8'h9C, 8'h02); settle(3);
    rd(8'hA0, r); chk("R5 nothing latched while disabled", r, 8'h00);

    // R8 debounce on line 2, high level
    wr(8'h9C, 8'h00); drive(8'h00);
    wr(8'h90, 8'h00); wr(8'h94, 8'h04); wr(8'hA8, 8'h04); wr(8'h9C, 8'h04);
    settle(20);
    drive(8'h04); settle(6); drive(8'h00);
    settle(40);
    chk("R8 short glitch rejected", irq_line, 8'h00);
    drive(8'h04); settle(8);
    chk("R8 not yet accepted", irq_line, 8'h00);
    settle(40);
    chk("R8 stable value accepted", irq_line, 8'h04);
    wr(8'hA8, 8'h00); wr(8'h9C, 8'h00); drive(8'h00);

    // R3 R4 R5 R6 R7 random operations against the model
    wr(8'h90, 8'h00); wr(8'h94, 8'h00); wr(8'h98, 8'hFF);
    settle(6);
    m_mode = '0; m_pol = '0; m_en = '0; m_lat = '0; m_pad = '0;
    for (int k = 0; k < 250; k++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 4);
      v  = 8'($urandom);
      case (op)
        0: begin
          logic [7:0] rise, fall;
          rise = v & ~m_pad;
          fall = ~v & m_pad;
          m_lat = m_lat | (m_mode & m_en & ((m_pol & rise) | (~m_pol & fall)));
          m_pad = v;
          drive(v);
        end
        1: begin wr(8'h98, v); m_lat = m_lat & ~v; end
        2: begin wr(8'h94, v); m_pol = v; end
        3: begin wr(8'h9C, v); m_en = v; m_lat = m_lat & v; end
        default: begin wr(8'h90, v); m_mode = v; m_lat = m_lat & v; end
      endcase
      settle(6);
      check_status("R7 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule